// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a logic array whose function is set by configuration registers rather than by fixed gates. A set of product terms is formed from the data inputs. Each term takes every input in one of three forms: true, complemented, or ignored. Each output is then the OR of a chosen subset of those terms. A per-output polarity bit can invert the result, and a disable input turns the outputs off. With the default parameters there are 16 inputs, 48 product terms and 8 outputs. The path from `data_in` to the outputs is purely combinational. Only the configuration is held in flops.

Configuration is loaded one term at a time through a synchronous write port. One write supplies the term index, that term's AND-plane row (two link bits per input) and its OR-plane row (one bit per output). A separate strobe loads the polarity bits. Reset returns every configuration bit to the erased pattern. In that pattern every term is blocked, every OR link is present and every output is non-inverting, so all outputs read 0 until terms are written. A parameter chooses how a disabled output looks: three-state (enable low, value 0) or open-collector (enable low, value 1).

Top module: `cfg_sop_array`

## Requirements
- R1: The AND-plane row of a term holds two link bits per input i. Bit 2i is the true-input link and bit 2i+1 is the complement link; a value of 1 means the link is intact. The term is 1 only when every input meets its kept links. With only the true link intact the literal is active high; with only the complement link intact it is active low.
- R2: If both links of any input are intact, that term is 0 for every input value.
- R3: If both links of an input are removed (bits 00), that input is a don't-care. A row of all zeros gives a term that is always 1.
- R4: Output k is the OR of every term whose OR-plane row has bit k set. A term whose bit k is cleared has no effect on output k.
- R5: When polarity bit k is 1, output k is the inverse of its OR result. When the bit is 0, the OR result passes unchanged.
- R6: After reset, every AND link is intact, every OR link is set and every polarity bit is 0. So with the outputs enabled, all of `out_val` is 0 for any input.
- R7: While `out_dis` is 1, `out_oe` is all zeros. In that state `out_val` is all zeros in three-state mode (the default) and all ones in open-collector mode. While `out_dis` is 0, `out_oe` is all ones.
- R8: A configuration write takes effect at the clock edge that samples its strobe, and not before. A change on `data_in` or `out_dis` shows on the outputs in the same cycle, with no clock in the path.
- R9: A row write whose term index is at or above the number of terms is ignored, and no stored term changes.
- R10: A polarity write leaves the stored rows unchanged. A row write leaves the polarity bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_idx | input | 6 | Term index for a row write |
| cfg_row_we | input | 1 | Row write strobe |
| cfg_and_row | input | 32 | AND-plane link pairs for the indexed term |
| cfg_or_row | input | 8 | OR-plane links from the indexed term to each output |
| cfg_pol_we | input | 1 | Polarity write strobe |
| cfg_pol | input | 8 | Polarity bits, 1 = invert |
| data_in | input | 16 | Logic inputs |
| out_dis | input | 1 | Output disable, active high |
| out_val | output | 8 | Output data value |
| out_oe | output | 8 | Per-output drive enable |

## Verification
Only configuration writes go through a register. A row or polarity write presented on one cycle changes the outputs after the rising edge that samples the strobe. The bench therefore checks the old value just before that edge and the new value in the low phase that follows. Changes on `data_in` and `out_dis` are due in the same cycle. The bench drives them on the falling edge and compares shortly afterwards, well before the next rising edge. Each comparison checks both outputs against a bench model of the programmed planes. Reset values are checked only after the internal release stages have settled.

// File: rtl/cfg_sop_pkg.sv
package cfg_sop_pkg;
  typedef enum logic {
    DRV_TRISTATE  = 1'b0,
    DRV_OPEN_COLL = 1'b1
  } drv_style_e;
endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_en,
  input  logic [2*N_IN-1:0] wr_row,
  input  logic [N_IN-1:0]   x,
  output logic [N_TERM-1:0] term
);
  localparam int ROW_W = 2 * N_IN;

  logic [ROW_W-1:0] link_q [N_TERM];
  logic [ROW_W-1:0] link_d [N_TERM];
  logic [ROW_W-1:0] lit;

  // next-state: one row replaced when index is in range
  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      link_d[t] = link_q[t];
      if (wr_en && (int'(wr_idx) == t)) link_d[t] = wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int t = 0; t < N_TERM; t++) link_q[t] <= '1;
    end else begin
      for (int t = 0; t < N_TERM; t++) link_q[t] <= link_d[t];
    end
  end

  // literal vector: even bit sees true input, odd bit sees complement
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = x[i];
    assign lit[2*i+1] = ~x[i];
  end

  // an intact link passes its literal, a removed link reads as 1
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term[t] = &(~link_q[t] | lit);
  end

  // R2
  both_intact_blocks_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (int'(wr_idx) < N_TERM) && (wr_row == '1)) |=> (term[$past(wr_idx)] == 1'b0));

  // R3
  all_removed_passes_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (int'(wr_idx) < N_TERM) && (wr_row == '0)) |=> (term[$past(wr_idx)] == 1'b1));
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_en,
  input  logic [N_OUT-1:0]  wr_row,
  input  logic [N_TERM-1:0] term,
  output logic [N_OUT-1:0]  sum
);
  logic [N_OUT-1:0]  sel_q [N_TERM];
  logic [N_OUT-1:0]  sel_d [N_TERM];
  logic [N_TERM-1:0] col   [N_OUT];

  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      sel_d[t] = sel_q[t];
      if (wr_en && (int'(wr_idx) == t)) sel_d[t] = wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int t = 0; t < N_TERM; t++) sel_q[t] <= '1;
    end else begin
      for (int t = 0; t < N_TERM; t++) sel_q[t] <= sel_d[t];
    end
  end

  // transpose per-term rows into per-output columns
  always_comb begin
    for (int k = 0; k < N_OUT; k++)
      for (int t = 0; t < N_TERM; t++)
        col[k][t] = sel_q[t][k];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    assign sum[k] = |(term & col[k]);
  end

  // R4
  no_term_no_sum_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (term == '0) |-> (sum == '0));
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage
  import cfg_sop_pkg::*;
#(
  parameter int         N_OUT = 8,
  parameter drv_style_e STYLE = DRV_TRISTATE
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             pol_we,
  input  logic [N_OUT-1:0] pol_in,
  input  logic [N_OUT-1:0] sum,
  input  logic             dis,
  output logic [N_OUT-1:0] val,
  output logic [N_OUT-1:0] oe
);
  localparam logic [N_OUT-1:0] OFF_VAL = (STYLE == DRV_OPEN_COLL) ? '1 : '0;

  logic [N_OUT-1:0] pol_q;
  logic [N_OUT-1:0] pol_d;
  logic [N_OUT-1:0] logic_out;

  always_comb begin
    pol_d = pol_q;
    if (pol_we) pol_d = pol_in;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pol_q <= '0;
    else          pol_q <= pol_d;
  end

  assign logic_out = sum ^ pol_q;

  always_comb begin
    if (dis) begin
      val = OFF_VAL;
      oe  = '0;
    end else begin
      val = logic_out;
      oe  = '1;
    end
  end

  // R7
  disabled_outputs_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    dis |-> ((oe == '0) && (val == OFF_VAL)));

  // R10
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pol_we |=> $stable(pol_q));
endmodule

// File: rtl/cfg_sop_array.sv
module cfg_sop_array
  import cfg_sop_pkg::*;
#(
  parameter int         N_IN   = 16,
  parameter int         N_TERM = 48,
  parameter int         N_OUT  = 8,
  parameter drv_style_e STYLE  = DRV_TRISTATE,
  localparam int        IDX_W  = $clog2(N_TERM),
  localparam int        ROW_W  = 2 * N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_row_we,
  input  logic [ROW_W-1:0] cfg_and_row,
  input  logic [N_OUT-1:0] cfg_or_row,
  input  logic             cfg_pol_we,
  input  logic [N_OUT-1:0] cfg_pol,
  input  logic [N_IN-1:0]  data_in,
  input  logic             out_dis,
  output logic [N_OUT-1:0] out_val,
  output logic [N_OUT-1:0] out_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic              row_en;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // out-of-range indices never reach the planes
  assign row_en = cfg_row_we && (int'(cfg_idx) < N_TERM);

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .IDX_W(IDX_W)) u_and (
    .clk(clk), .rst_q_n(rst_q_n), .wr_idx(cfg_idx), .wr_en(row_en),
    .wr_row(cfg_and_row), .x(data_in), .term(term));

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .IDX_W(IDX_W)) u_or (
    .clk(clk), .rst_q_n(rst_q_n), .wr_idx(cfg_idx), .wr_en(row_en),
    .wr_row(cfg_or_row), .term(term), .sum(sum));

  sop_out_stage #(.N_OUT(N_OUT), .STYLE(STYLE)) u_out (
    .clk(clk), .rst_q_n(rst_q_n), .pol_we(cfg_pol_we), .pol_in(cfg_pol),
    .sum(sum), .dis(out_dis), .val(out_val), .oe(out_oe));

  // R9
  bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_row_we && (int'(cfg_idx) >= N_TERM) && !cfg_pol_we && !out_dis)
      |=> ($stable(data_in) -> $stable(out_val)));
endmodule

// File: tb/cfg_sop_array_bench.sv
module cfg_sop_array_bench;
  localparam int CLK_P  = 10;
  localparam int N_IN   = 16;
  localparam int N_TERM = 48;
  localparam int N_OUT  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_idx;
  logic        cfg_row_we;
  logic [31:0] cfg_and_row;
  logic [7:0]  cfg_or_row;
  logic        cfg_pol_we;
  logic [7:0]  cfg_pol;
  logic [15:0] data_in;
  logic        out_dis;
  logic [7:0]  out_val;
  logic [7:0]  out_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_and [N_TERM];
  logic [7:0]  m_or  [N_TERM];
  logic [7:0]  m_pol;

  always #(CLK_P/2) clk = ~clk;

  cfg_sop_array u_cfg_sop_array (
    .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_row_we(cfg_row_we),
    .cfg_and_row(cfg_and_row), .cfg_or_row(cfg_or_row), .cfg_pol_we(cfg_pol_we),
    .cfg_pol(cfg_pol), .data_in(data_in), .out_dis(out_dis),
    .out_val(out_val), .out_oe(out_oe));

  function automatic logic [7:0] model_out(input logic [15:0] x, input logic dis);
    logic [7:0] s;
    s = '0;
    if (dis) return 8'h00;
    for (int t = 0; t < N_TERM; t++) begin
      logic hit;
      hit = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (m_and[t][2*i]   && !x[i]) hit = 1'b0;
        if (m_and[t][2*i+1] &&  x[i]) hit = 1'b0;
      end
      if (hit) s = s | m_or[t];
    end
    return s ^ m_pol;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp_val);
    logic [7:0] exp_oe;
    exp_oe = out_dis ? 8'h00 : 8'hFF;
    n_chk++;
    if (out_val !== exp_val || out_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: val=%h oe=%h expected val=%h oe=%h (in=%h)",
               tag, out_val, out_oe, exp_val, exp_oe, data_in);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] x, input logic dis);
    @(negedge clk);
    data_in = x;
    out_dis = dis;
    #1;
    check(tag, model_out(x, dis));
  endtask

  task automatic write_row(input int idx, input logic [31:0] a, input logic [7:0] o);
    @(negedge clk);
    cfg_idx     = 6'(idx);
    cfg_and_row = a;
    cfg_or_row  = o;
    cfg_row_we  = 1'b1;
    @(negedge clk);
    cfg_row_we  = 1'b0;
    if (idx < N_TERM) begin
      m_and[idx] = a;
      m_or[idx]  = o;
    end
  endtask

  task automatic write_pol(input logic [7:0] p);
    @(negedge clk);
    cfg_pol    = p;
    cfg_pol_we = 1'b1;
    @(negedge clk);
    cfg_pol_we = 1'b0;
    m_pol      = p;
  endtask

  function automatic logic [31:0] rand_and_row();
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < N_IN; i++) begin
      int p;
      p = $urandom_range(0, 99);
      if (p < 12)      r[2*i]   = 1'b1;
      else if (p < 24) r[2*i+1] = 1'b1;
      else if (p < 25) r[2*i +: 2] = 2'b11;
    end
    return r;
  endfunction

  // input that satisfies the kept literals of a term
  function automatic logic [15:0] hit_vec(input int t);
    logic [15:0] x;
    x = 16'($urandom);
    for (int i = 0; i < N_IN; i++) begin
      if (m_and[t][2*i +: 2] == 2'b01) x[i] = 1'b1;
      if (m_and[t][2*i +: 2] == 2'b10) x[i] = 1'b0;
    end
    return x;
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    for (int t = 0; t < N_TERM; t++) begin
      m_and[t] = '1;
      m_or[t]  = '1;
    end
    m_pol       = '0;
    rst_n       = 1'b0;
    cfg_idx     = '0;
    cfg_row_we  = 1'b0;
    cfg_and_row = '0;
    cfg_or_row  = '0;
    cfg_pol_we  = 1'b0;
    cfg_pol     = '0;
    data_in     = '0;
    out_dis     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: erased state reads 0 on every output
    for (int v = 0; v < 8; v++) apply("R6", 16'($urandom), 1'b0);
    apply("R6", 16'hFFFF, 1'b0);

    // R8: write not visible before the sampling edge, visible after
    @(negedge clk);
    cfg_idx = 6'd0; cfg_and_row = '0; cfg_or_row = 8'h01; cfg_row_we = 1'b1;
    #1;
    check("R8", 8'h00);
    @(negedge clk);
    cfg_row_we = 1'b0;
    m_and[0] = '0; m_or[0] = 8'h01;
    #1;
    check("R8", 8'h01);

    // R3: all-removed term always on
    apply("R3", 16'h0000, 1'b0);
    apply("R3", 16'hA5C3, 1'b0);

    // R1: true-only literal on input 3 feeds output 1
    write_row(1, 32'h1 << 6, 8'h02);
    apply("R1", 16'h0008, 1'b0);
    apply("R1", 16'hFFF7, 1'b0);
    // R1: complement-only literal on input 5 feeds output 2
    write_row(2, 32'h2 << 10, 8'h04);
    apply("R1", 16'h0000, 1'b0);
    apply("R1", 16'h0020, 1'b0);

    // R2: both links intact on input 0 blocks term
    write_row(3, 32'h3, 8'h08);
    apply("R2", 16'h0000, 1'b0);
    apply("R2", 16'hFFFF, 1'b0);

    // R5 / R10: invert output 7, rows untouched
    write_pol(8'h80);
    apply("R5", 16'h0008, 1'b0);
    apply("R10", 16'h0020, 1'b0);

    // R9: out-of-range index writes change nothing
    write_row(50, '0, 8'hFF);
    apply("R9", 16'h1234, 1'b0);
    write_row(63, '0, 8'hFF);
    apply("R9", 16'h0000, 1'b0);

    // R10: row write keeps polarity
    write_row(4, 32'h3 << 2, 8'hF0);
    apply("R10", 16'hBEEF, 1'b0);

    // R7: disable
    apply("R7", 16'h0008, 1'b1);
    apply("R7", 16'hFFFF, 1'b1);
    apply("R7", 16'h0008, 1'b0);

    // R4: random programs, random inputs, disable toggling
    for (int round = 0; round < 4; round++) begin
      for (int t = 0; t < N_TERM; t++)
        write_row(t, rand_and_row(), 8'($urandom));
      write_pol(8'($urandom));
      for (int v = 0; v < 400; v++) begin
        logic [15:0] x;
        x = ($urandom_range(0, 1) == 0) ? hit_vec($urandom_range(0, N_TERM-1))
                                        : 16'($urandom);
        apply("R4", x, $urandom_range(0, 9) == 0);
      end
    end

    // R4: only one term linked per output
    for (int t = 0; t < N_TERM; t++) write_row(t, rand_and_row(), 8'h00);
    write_row(7, 32'h1 << 8, 8'h10);
    write_pol(8'h00);
    apply("R4", 16'h0010, 1'b0);
    apply("R4", 16'h0000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule